// File: doc/BRIEF.md
# Retriggerable PWM Pulse Timer

This block is a 16-bit counter that emits a pulse-width-modulated waveform only after it has been started by a trigger. When the enable input is raised, the counter parks at its all-ones value and waits without driving any pulse. A trigger moves it to zero and starts the count. The trigger is either a chosen edge on an external input or a one-cycle software trigger bit. A further trigger at any point in the cycle restarts the waveform from zero.

Two compare values shape the waveform. A period value sets the cycle length, which is (period + 1) count ticks. A width value sets how many ticks, counted from zero, the output stays at its active level. Software writes both values into holding registers. They reach the working buffers only when the counter wraps at the period match, so a running cycle is never cut short or stretched by a write.

The counter advances only on clocks where the count-clock enable is high. An interrupt pulse marks each period wrap, and another marks each width match.

Top module: `trig_pwm_timer`

## Requirements
- R1: While enabled and not yet triggered, the counter rests at FFFFh, the output stays at its inactive level and neither interrupt pulses.
- R2: A 1 on the software trigger input sets an internal bit at the next clock, and that bit clears itself one clock later. On the following count tick the counter moves from FFFFh to 0, so the output turns active two clocks after the write.
- R3: A trigger arriving while the waveform runs clears the counter to 0 on the next count tick and starts a full new cycle from there.
- R4: The external input passes through two synchronising flip-flops before edge detection. The edge-select code is 00 = none, 01 = rising, 10 = falling, 11 = both. A selected edge turns the output active three clocks after the input changes, and an edge that is not selected is ignored.
- R5: The counter runs 0 to the period buffer value and then wraps to 0, giving a cycle of (period + 1) ticks. The period interrupt is high in the clock after the tick on which the counter equalled the period buffer.
- R6: The output is active from count 0 until the count reaches the width buffer value, so it is active for exactly width ticks per cycle.
- R7: The width interrupt is high in the clock after the tick on which the counter equalled the width buffer value.
- R8: Writes to the period and width registers while running take effect only at the next period wrap. The cycle in progress keeps its old values.
- R9: A width of 0 keeps the output inactive for the whole cycle. A width greater than the period keeps it active for the whole cycle and produces no width interrupt.
- R10: With the polarity input at 1 the active level is high. With it at 0 the active level is low, and the idle output is then high.
- R11: Dropping the enable stops the count, parks the counter at FFFFh, drives the output inactive and copies the registers straight into the buffers.
- R12: The counter changes only on clocks with the count-clock enable high. A trigger seen while that enable is low is held and takes effect on the next tick.
- R13: If a trigger and a period match fall on the same tick, the trigger wins. The counter restarts at 0, no period interrupt is raised and the buffers are not reloaded.
- R14: Each interrupt is a single-clock pulse for any period of at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable; the counter ticks only when high |
| enable | input | 1 | Timer enable; low stops and parks the timer |
| edge_sel | input | 2 | External edge select: 00 none, 01 rising, 10 falling, 11 both |
| ext_trig | input | 1 | Asynchronous external trigger input |
| sw_trig | input | 1 | Software trigger write strobe |
| active_high | input | 1 | Output polarity: 1 active high, 0 active low |
| period_wr | input | 1 | Write strobe for the period register |
| period_data | input | 16 | Period register write data |
| width_wr | input | 1 | Write strobe for the width register |
| width_data | input | 16 | Width register write data |
| pwm_out | output | 1 | PWM waveform output |
| period_irq | output | 1 | Period-match interrupt pulse |
| width_irq | output | 1 | Width-match interrupt pulse |

## Verification
A trigger and a period wrap can fall on the same count tick. In that case the restart and the buffer reload compete for the counter. The bench provokes this by issuing a software trigger two clocks before the counter reaches the period value, with a smaller period already written to the holding register. It then checks that no period interrupt appears at the restart and that the next cycle still has the old length, which shows the trigger took priority and the reload was skipped.

// File: rtl/trig_pwm_pkg.sv
package trig_pwm_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
    } cmp_pair_t;

    typedef struct packed {
        logic period_hit;
        logic width_hit;
    } match_t;

    function automatic logic edge_pick(input logic [1:0] sel, input logic rise, input logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/trig_pwm_trigsel.sv
module trig_pwm_trigsel
    import trig_pwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       ext_in,
    input  logic [1:0] edge_sel,
    input  logic       sw_wr,
    output logic       trig
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   sw_bit_q;
    logic                   rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            prev_q   <= 1'b0;
            sw_bit_q <= 1'b0;
        end else begin
            sync_q[0] <= ext_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            prev_q   <= sync_q[LAST];
            sw_bit_q <= sw_wr & enable;
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;
    assign trig = enable & (edge_pick(edge_sel, rise, fall) | sw_bit_q);

    // R2: the software bit never survives a disabled cycle
    p_swbit_off_r2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !sw_bit_q);

    // R4: with no edge selected only the software bit can trigger
    p_no_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_sel == EDGE_NONE) && !sw_bit_q |-> !trig);

endmodule

// File: rtl/trig_pwm_cmpbuf.sv
module trig_pwm_cmpbuf
    import trig_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             load,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_data,
    input  logic             width_wr,
    input  logic [CNT_W-1:0] width_data,
    output cmp_pair_t        buf_q
);

    cmp_pair_t reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            if (period_wr) reg_q.period <= period_data;
            if (width_wr)  reg_q.width  <= width_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
        end else if (!enable || load) begin
            buf_q <= reg_q;
        end
    end

    // R8: working values stay fixed between wraps while enabled
    p_buf_hold_r8: assert property (@(posedge clk) disable iff (rst)
        enable && !load |=> $stable(buf_q));

endmodule

// File: rtl/trig_pwm_core.sv
module trig_pwm_core
    import trig_pwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      tick,
    input  logic      trig,
    input  logic      active_high,
    input  cmp_pair_t cmp,
    output logic      load,
    output logic      pwm_out,
    output logic      period_irq,
    output logic      width_irq
);

    logic [CNT_W-1:0] cnt_q;
    run_state_e       state_q;
    logic             pend_q;
    logic             per_irq_q, wid_irq_q;
    logic             take, advance, pwm_active;
    match_t           hit;

    assign take    = enable & tick & (trig | pend_q);
    assign advance = enable & tick & (state_q == ST_RUN) & ~take;

    always_comb begin
        hit.period_hit = advance & (cnt_q == cmp.period);
        hit.width_hit  = advance & (cnt_q == cmp.width);
    end

    assign load = hit.period_hit;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q     <= '1;
            state_q   <= ST_IDLE;
            pend_q    <= 1'b0;
            per_irq_q <= 1'b0;
            wid_irq_q <= 1'b0;
        end else begin
            per_irq_q <= hit.period_hit;
            wid_irq_q <= hit.width_hit;
            if (take) begin
                cnt_q   <= '0;
                state_q <= ST_RUN;
                pend_q  <= 1'b0;
            end else begin
                if (trig && !tick) pend_q <= 1'b1;
                if (advance) cnt_q <= hit.period_hit ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign pwm_active = (state_q == ST_RUN) && (cnt_q < cmp.width);
    assign pwm_out    = active_high ? pwm_active : ~pwm_active;
    assign period_irq = per_irq_q;
    assign width_irq  = wid_irq_q;

    // R1: an idle timer always parks at all ones
    p_idle_parks_r1: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE |-> cnt_q == '1);

    // R3: an accepted trigger restarts at zero in run state
    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        take |=> (cnt_q == '0) && (state_q == ST_RUN));

    // R5: a period match wraps the count and flags the interrupt
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        hit.period_hit |=> (cnt_q == '0) && period_irq);

    // R11: disabling parks the counter with the output inactive
    p_off_r11: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt_q == '1) && !pwm_active && !period_irq && !width_irq);

    // R12: no count tick, no counter change
    p_gate_r12: assert property (@(posedge clk) disable iff (rst)
        enable && !tick |=> $stable(cnt_q));

endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer
    import trig_pwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             enable,
    input  logic [1:0]       edge_sel,
    input  logic             ext_trig,
    input  logic             sw_trig,
    input  logic             active_high,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_data,
    input  logic             width_wr,
    input  logic [CNT_W-1:0] width_data,
    output logic             pwm_out,
    output logic             period_irq,
    output logic             width_irq
);

    logic      trig;
    logic      load;
    cmp_pair_t cmp;

    trig_pwm_trigsel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .ext_in   (ext_trig),
        .edge_sel (edge_sel),
        .sw_wr    (sw_trig),
        .trig     (trig)
    );

    trig_pwm_cmpbuf u_buf (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .load        (load),
        .period_wr   (period_wr),
        .period_data (period_data),
        .width_wr    (width_wr),
        .width_data  (width_data),
        .buf_q       (cmp)
    );

    trig_pwm_core u_core (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .tick        (cnt_en),
        .trig        (trig),
        .active_high (active_high),
        .cmp         (cmp),
        .load        (load),
        .pwm_out     (pwm_out),
        .period_irq  (period_irq),
        .width_irq   (width_irq)
    );

endmodule

// File: tb/trig_pwm_timer_test.sv
module trig_pwm_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b1;
    logic        enable = 1'b0;
    logic [1:0]  edge_sel = 2'b00;
    logic        ext_trig = 1'b0;
    logic        sw_trig = 1'b0;
    logic        active_high = 1'b1;
    logic        period_wr = 1'b0;
    logic [15:0] period_data = '0;
    logic        width_wr = 1'b0;
    logic [15:0] width_data = '0;
    logic        pwm_out, period_irq, width_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trig_pwm_timer uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .enable(enable),
        .edge_sel(edge_sel), .ext_trig(ext_trig), .sw_trig(sw_trig),
        .active_high(active_high), .period_wr(period_wr), .period_data(period_data),
        .width_wr(width_wr), .width_data(width_data),
        .pwm_out(pwm_out), .period_irq(period_irq), .width_irq(width_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int active_lvl();
        return (pwm_out == active_high) ? 1 : 0;
    endfunction

    // disable, load registers (buffers follow while disabled), then enable
    task automatic configure(input int per, input int wid, input logic ext0);
        enable = 1'b0;
        cnt_en = 1'b1;
        ext_trig = ext0;
        period_wr = 1'b1; period_data = 16'(per);
        width_wr  = 1'b1; width_data  = 16'(wid);
        step(1);
        period_wr = 1'b0; width_wr = 1'b0;
        step(4);
        enable = 1'b1;
        step(1);
    endtask

    task automatic sw_pulse();
        sw_trig = 1'b1;
        step(1);
        sw_trig = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            step(1);
            n++;
        end while (!period_irq && n < 1000);
    endtask

    // samples offsets 0..len-1, starting at the current negedge
    task automatic window(input int len, output int act, output int wpos, output int wcnt);
        act = 0; wpos = -1; wcnt = 0;
        for (int j = 0; j < len; j++) begin
            if (j > 0) step(1);
            act += active_lvl();
            if (width_irq) begin
                wcnt++;
                if (wpos < 0) wpos = j;
            end
        end
    endtask

    task automatic test_reset();
        chk("R1 reset output", int'(pwm_out), 0);
        chk("R1 reset period_irq", int'(period_irq), 0);
        chk("R1 reset width_irq", int'(width_irq), 0);
    endtask

    task automatic test_idle();
        int bad = 0;
        configure(9, 3, 1'b0);
        for (int j = 0; j < 40; j++) begin
            step(1);
            if (pwm_out || period_irq || width_irq) bad++;
        end
        chk("R1 idle without trigger", bad, 0);
    endtask

    task automatic test_basic();
        int n, act, wpos, wcnt;
        configure(9, 3, 1'b0);
        sw_pulse();
        chk("R2 not yet active one clock after write", active_lvl(), 0);
        step(1);
        chk("R2 active two clocks after write", active_lvl(), 1);
        wait_irq(n);
        chk("R5 first period interrupt seen", int'(period_irq), 1);
        window(10, act, wpos, wcnt);
        chk("R6 active ticks per cycle", act, 3);
        chk("R7 width interrupt offset", wpos, 4);
        chk("R14 width interrupt single pulse", wcnt, 1);
        step(1);
        chk("R5 period of P+1 ticks", int'(period_irq), 1);
        step(1);
        chk("R14 period interrupt single pulse", int'(period_irq), 0);
    endtask

    task automatic test_buffer();
        int n;
        configure(9, 3, 1'b0);
        sw_pulse();
        wait_irq(n);
        step(1);
        period_wr = 1'b1; period_data = 16'd4;
        width_wr  = 1'b1; width_data  = 16'd2;
        step(1);
        period_wr = 1'b0; width_wr = 1'b0;
        wait_irq(n);
        chk("R8 running cycle keeps old period", n, 8);
        wait_irq(n);
        chk("R8 new period after wrap", n, 5);
    endtask

    task automatic test_retrigger();
        int n;
        configure(9, 3, 1'b0);
        sw_pulse();
        wait_irq(n);
        step(6);
        chk("R3 inactive before retrigger", active_lvl(), 0);
        sw_pulse();
        chk("R3 still inactive one clock after", active_lvl(), 0);
        step(1);
        chk("R3 restart drives active", active_lvl(), 1);
        wait_irq(n);
        chk("R3 full cycle after restart", n, 10);
    endtask

    task automatic ext_case(input logic [1:0] sel, input logic start, input string req);
        configure(9, 3, start);
        edge_sel = sel;
        step(2);
        ext_trig = ~start;
        step(2);
        chk({req, " idle during sync"}, active_lvl(), 0);
        step(1);
        chk({req, " triggered by edge"}, active_lvl(), 1);
    endtask

    task automatic test_ext();
        int bad = 0;
        ext_case(2'b01, 1'b0, "R4 rising");
        ext_case(2'b10, 1'b1, "R4 falling");
        ext_case(2'b11, 1'b0, "R4 both");
        // falling selected: a rising edge is ignored
        configure(9, 3, 1'b0);
        edge_sel = 2'b10;
        step(2);
        ext_trig = 1'b1;
        for (int j = 0; j < 12; j++) begin step(1); if (pwm_out || period_irq) bad++; end
        chk("R4 unselected rising ignored", bad, 0);
        // none selected: both edges ignored
        bad = 0;
        configure(9, 3, 1'b0);
        edge_sel = 2'b00;
        step(2);
        ext_trig = 1'b1;
        for (int j = 0; j < 8; j++) begin step(1); if (pwm_out || period_irq) bad++; end
        ext_trig = 1'b0;
        for (int j = 0; j < 8; j++) begin step(1); if (pwm_out || period_irq) bad++; end
        chk("R4 code 00 ignores edges", bad, 0);
        edge_sel = 2'b00;
    endtask

    task automatic test_extremes();
        int n, act, wpos, wcnt;
        configure(9, 0, 1'b0);
        sw_pulse();
        wait_irq(n);
        window(10, act, wpos, wcnt);
        chk("R9 width 0 never active", act, 0);
        configure(5, 8, 1'b0);
        sw_pulse();
        wait_irq(n);
        window(6, act, wpos, wcnt);
        chk("R9 width above period always active", act, 6);
        chk("R9 no width interrupt above period", wcnt, 0);
        step(1);
        chk("R9 period still 6 ticks", int'(period_irq), 1);
    endtask

    task automatic test_polarity();
        int n, act, wpos, wcnt;
        active_high = 1'b0;
        configure(9, 3, 1'b0);
        chk("R10 idle output high when active-low", int'(pwm_out), 1);
        sw_pulse();
        wait_irq(n);
        window(10, act, wpos, wcnt);
        chk("R10 active-low ticks", act, 3);
        active_high = 1'b1;
    endtask

    task automatic test_disable();
        int n, bad = 0;
        configure(9, 3, 1'b0);
        sw_pulse();
        wait_irq(n);
        step(1);
        period_wr = 1'b1; period_data = 16'd4;
        step(1);
        period_wr = 1'b0;
        chk("R11 running active before disable", active_lvl(), 1);
        enable = 1'b0;
        for (int j = 0; j < 12; j++) begin step(1); if (pwm_out || period_irq || width_irq) bad++; end
        chk("R11 disabled output quiet", bad, 0);
        enable = 1'b1;
        step(1);
        sw_pulse();
        step(1);
        wait_irq(n);
        chk("R11 buffers loaded while disabled", n, 5);
    endtask

    task automatic test_gate();
        int n;
        configure(9, 3, 1'b0);
        sw_pulse();
        wait_irq(n);
        n = 0;
        cnt_en = 1'b0;
        do begin
            step(1);
            n++;
            cnt_en = ~cnt_en;
        end while (!period_irq && n < 1000);
        chk("R12 half-rate ticks double the cycle", n, 20);
        step(1);
        chk("R14 gated period interrupt single pulse", int'(period_irq), 0);
        // trigger held while count enable is low
        configure(9, 3, 1'b0);
        cnt_en = 1'b0;
        sw_pulse();
        step(5);
        chk("R12 no start without tick", active_lvl(), 0);
        cnt_en = 1'b1;
        step(1);
        chk("R12 pending trigger starts on tick", active_lvl(), 1);
    endtask

    task automatic test_coincide();
        int n;
        configure(9, 3, 1'b0);
        sw_pulse();
        wait_irq(n);
        step(1);
        period_wr = 1'b1; period_data = 16'd4;
        step(1);
        period_wr = 1'b0;
        step(6);
        sw_pulse();
        step(1);
        chk("R13 no period interrupt on trigger tie", int'(period_irq), 0);
        chk("R13 restarted active", active_lvl(), 1);
        wait_irq(n);
        chk("R13 buffers not reloaded on tie", n, 10);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        test_reset();
        test_idle();
        test_basic();
        test_buffer();
        test_retrigger();
        test_ext();
        test_extremes();
        test_polarity();
        test_disable();
        test_gate();
        test_coincide();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule